// File: doc/BRIEF.md
# Legacy Disk I/O Access Trap

This block watches host I/O cycles aimed at the legacy disk controller and decides, for each one, whether the controller sees it. Software arms a trap separately for each attached drive. An access to the legacy task-file window (1F0h to 1F7h) or the alternate status/control port (3F6h) for an armed drive is swallowed. It is not forwarded, a read of it returns all ones, and a system-management interrupt request goes out. Accesses to the bus-master register block behave differently: for an armed drive they are still performed, but they are also reported through the interrupt request.

Every trapped access sets a sticky activity bit for the drive that caused it. Software clears these bits with a write-one-to-clear mask. For task-file and control accesses, the drive being addressed is the one the controller currently has selected. The block therefore keeps a shadow of the drive-select bit (bit 4 of writes to 1F6h), and updates it only from writes that actually reach the controller. For bus-master accesses, the drive comes with the hit indication.

Top module: `io_smi_trap`

## Requirements
- R1: After reset, `fwd_o`, `rd_ones_o` and `smi_req_o` are low, `trap_sts_o` is all zero, and the shadowed selected drive is drive 0.
- R2: An access is in the legacy window only for addresses 1F0h through 1F7h and exactly 3F6h. Addresses 1EFh, 1F8h, 3F5h and 3F7h without `bm_hit_i` produce no forward, no all-ones read, no request and no status change.
- R3: A legacy access whose selected drive has its `trap_en_i` bit clear raises `fwd_o` in the same cycle, with no request and no status change.
- R4: A legacy access whose selected drive has its `trap_en_i` bit set keeps `fwd_o` low in that cycle. `smi_req_o` is high in the following cycle only, for exactly one cycle.
- R5: `rd_ones_o` is high in the same cycle as a trapped legacy read. It stays low for trapped writes, untrapped accesses and bus-master accesses.
- R6: An access with `bm_hit_i` high is always forwarded in the same cycle. If `trap_en_i[bm_dev_i]` is set, `smi_req_o` pulses the next cycle and status bit `bm_dev_i` is set. An enable bit for a different drive has no effect.
- R7: A trapped access sets `trap_sts_o[d]` (d the trapped drive) one cycle after the access. The bit then holds through any number of idle cycles.
- R8: A cycle with `sts_clr_i` high clears the status bits selected by ones in `sts_clr_mask_i` on the next edge, leaving the others unchanged. When the same bit is set and cleared in one cycle, the set wins.
- R9: The selected drive for legacy accesses is bit 4 of the data of the most recent forwarded write to 1F6h (0 = drive 0, 1 = drive 1). A trapped write to 1F6h leaves it unchanged.
- R10: With `io_rd_i` and `io_wr_i` both low, the block takes no action, whatever the address, `bm_hit_i` and enables: no forward, no all-ones read, no request and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_rd_i | input | 1 | I/O read strobe, one cycle per access |
| io_wr_i | input | 1 | I/O write strobe, one cycle per access |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | I/O write data (low byte) |
| bm_hit_i | input | 1 | Access decodes to the bus-master register block |
| bm_dev_i | input | 1 | Drive that owns the bus-master register hit |
| trap_en_i | input | 2 | Trap enable, one bit per drive |
| sts_clr_i | input | 1 | Status clear strobe |
| sts_clr_mask_i | input | 2 | Write-one-to-clear mask for the status bits |
| fwd_o | output | 1 | Pass this access to the disk controller |
| rd_ones_o | output | 1 | Return all-ones data for this read |
| smi_req_o | output | 1 | One-cycle system-management interrupt request |
| trap_sts_o | output | 2 | Sticky per-drive trap activity status |

## Verification
The one hidden piece of state is the shadowed drive select. If it goes wrong, nothing shows at the moment it goes wrong. It shows on the next task-file access with per-drive enables that differ: the wrong drive's enable then decides `fwd_o` in that same cycle, and the wrong status bit rises one cycle later. The bench therefore moves the shadow with forwarded and with swallowed writes to 1F6h, then probes it with asymmetric enables. A status bit that fails to stick, or a clear that hits the wrong bits, shows at `trap_sts_o` one edge after the event. An extra or stretched interrupt request shows in the cycle after the access.

// File: rtl/trap_pkg.sv
package trap_pkg;
  // Classification of one host I/O cycle.
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_LEGACY = 2'd1,
    ACC_BUSMST = 2'd2
  } acc_kind_e;

  localparam int unsigned NUM_WINDOWS = 2;

  function automatic int unsigned dev_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/legacy_decode.sv
module legacy_decode #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [15:0] TF_BASE    = 16'h01F0,
  parameter int unsigned TF_SPAN    = 8,
  parameter logic [15:0] CTL_ADDR   = 16'h03F6,
  parameter int unsigned DEVSEL_OFS = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              win_hit_o,
  output logic              devsel_hit_o
);
  localparam int unsigned NW = trap_pkg::NUM_WINDOWS;
  localparam logic [ADDR_W-1:0] TF_LO  = ADDR_W'(TF_BASE);
  localparam logic [ADDR_W-1:0] TF_HI  = ADDR_W'(TF_BASE) + ADDR_W'(TF_SPAN - 1);
  localparam logic [ADDR_W-1:0] CTL_AD = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] DSEL   = ADDR_W'(TF_BASE) + ADDR_W'(DEVSEL_OFS);

  logic [NW-1:0] win_match;

  generate
    for (genvar w = 0; w < NW; w++) begin : g_win
      localparam logic [ADDR_W-1:0] LO = (w == 0) ? TF_LO : CTL_AD;
      localparam logic [ADDR_W-1:0] HI = (w == 0) ? TF_HI : CTL_AD;
      always_comb begin
        win_match[w] = (addr_i >= LO) && (addr_i <= HI);
      end
    end
  endgenerate

  always_comb begin
    win_hit_o    = |win_match;
    devsel_hit_o = (addr_i == DSEL);
  end
endmodule

// File: rtl/drive_shadow.sv
module drive_shadow #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEV_W   = 1,
  parameter int unsigned SEL_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DEV_W-1:0]  cur_dev_o
);
  logic [DEV_W-1:0] sel_q;
  logic [DEV_W-1:0] sel_d;

  always_comb begin
    sel_d = sel_q;
    if (load_i) sel_d = wdata_i[SEL_LSB +: DEV_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign cur_dev_o = sel_q;

  // R9: the selection only moves after a forwarded select write
  assert_sel_only_on_fwd_write_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(load_i));
endmodule

// File: rtl/trap_status.sv
module trap_status #(
  parameter int unsigned NUM_DEV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] set_i,
  input  logic               clr_i,
  input  logic [NUM_DEV-1:0] clr_mask_i,
  output logic [NUM_DEV-1:0] sts_o
);
  logic [NUM_DEV-1:0] sts_q;
  logic [NUM_DEV-1:0] sts_d;

  generate
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_bit
      always_comb begin
        sts_d[d] = sts_q[d];
        if (clr_i && clr_mask_i[d]) sts_d[d] = 1'b0;
        if (set_i[d])               sts_d[d] = 1'b1;
      end

      // R7: a bit only rises after a trap for its drive
      assert_rise_needs_trap_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(sts_q[d]) |-> $past(set_i[d]));

      // R8: a bit only falls after a masked clear
      assert_fall_needs_clear_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(sts_q[d]) |-> $past(clr_i && clr_mask_i[d]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/io_smi_trap.sv
module io_smi_trap #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NUM_DEV    = 2,
  parameter logic [15:0] TF_BASE    = 16'h01F0,
  parameter int unsigned TF_SPAN    = 8,
  parameter logic [15:0] CTL_ADDR   = 16'h03F6,
  parameter int unsigned DEVSEL_OFS = 6,
  parameter int unsigned SEL_LSB    = 4,
  localparam int unsigned DEV_W     = trap_pkg::dev_width(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_rd_i,
  input  logic               io_wr_i,
  input  logic [ADDR_W-1:0]  io_addr_i,
  input  logic [DATA_W-1:0]  io_wdata_i,
  input  logic               bm_hit_i,
  input  logic [DEV_W-1:0]   bm_dev_i,
  input  logic [NUM_DEV-1:0] trap_en_i,
  input  logic               sts_clr_i,
  input  logic [NUM_DEV-1:0] sts_clr_mask_i,
  output logic               fwd_o,
  output logic               rd_ones_o,
  output logic               smi_req_o,
  output logic [NUM_DEV-1:0] trap_sts_o
);
  import trap_pkg::*;

  logic             win_hit;
  logic             devsel_hit;
  logic [DEV_W-1:0] cur_dev;
  acc_kind_e        kind;
  logic             leg_armed;
  logic             bm_armed;
  logic             trap_leg;
  logic             trap_bm;
  logic             sel_load;
  logic [NUM_DEV-1:0] set_vec;
  logic             smi_q;
  logic             smi_d;

  legacy_decode #(
    .ADDR_W(ADDR_W), .TF_BASE(TF_BASE), .TF_SPAN(TF_SPAN),
    .CTL_ADDR(CTL_ADDR), .DEVSEL_OFS(DEVSEL_OFS)
  ) u_dec (
    .addr_i      (io_addr_i),
    .win_hit_o   (win_hit),
    .devsel_hit_o(devsel_hit)
  );

  // Classify the current cycle; the legacy window takes priority.
  always_comb begin
    kind = ACC_NONE;
    if (io_rd_i || io_wr_i) begin
      if (win_hit)       kind = ACC_LEGACY;
      else if (bm_hit_i) kind = ACC_BUSMST;
    end
  end

  always_comb begin
    leg_armed = trap_en_i[cur_dev];
    bm_armed  = trap_en_i[bm_dev_i];
    trap_leg  = (kind == ACC_LEGACY) && leg_armed;
    trap_bm   = (kind == ACC_BUSMST) && bm_armed;
    fwd_o     = ((kind == ACC_LEGACY) && !leg_armed) || (kind == ACC_BUSMST);
    rd_ones_o = trap_leg && io_rd_i;
    sel_load  = io_wr_i && (kind == ACC_LEGACY) && !leg_armed && devsel_hit;
    smi_d     = trap_leg || trap_bm;
  end

  generate
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_set
      always_comb begin
        set_vec[d] = (trap_leg && (cur_dev == DEV_W'(d))) ||
                     (trap_bm  && (bm_dev_i == DEV_W'(d)));
      end
    end
  endgenerate

  drive_shadow #(.DATA_W(DATA_W), .DEV_W(DEV_W), .SEL_LSB(SEL_LSB)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (sel_load),
    .wdata_i  (io_wdata_i),
    .cur_dev_o(cur_dev)
  );

  trap_status #(.NUM_DEV(NUM_DEV)) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_vec),
    .clr_i     (sts_clr_i),
    .clr_mask_i(sts_clr_mask_i),
    .sts_o     (trap_sts_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi_q <= 1'b0;
    else        smi_q <= smi_d;
  end

  assign smi_req_o = smi_q;

  // R4: a request follows an access by one cycle
  assert_smi_after_access_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    smi_req_o |-> $past(io_rd_i || io_wr_i));

  // R6: any request comes with a status bit already visible
  assert_smi_with_status_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    smi_req_o |-> (trap_sts_o != '0));

  // R5: an all-ones read is never also forwarded
  assert_ones_not_forwarded_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    rd_ones_o |-> !fwd_o);

  // R10: no strobe, no forward
  assert_idle_no_forward_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    !(io_rd_i || io_wr_i) |-> !fwd_o);
endmodule

// File: tb/sim_io_smi_trap.sv
module sim_io_smi_trap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_rd, io_wr, bm_hit, bm_dev, sts_clr;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic [1:0]  trap_en, clr_mask;
  logic        fwd, rd_ones, smi;
  logic [1:0]  sts;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  io_smi_trap u0 (
    .clk(clk), .rst_n(rst_n), .io_rd_i(io_rd), .io_wr_i(io_wr),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .bm_hit_i(bm_hit),
    .bm_dev_i(bm_dev), .trap_en_i(trap_en), .sts_clr_i(sts_clr),
    .sts_clr_mask_i(clr_mask), .fwd_o(fwd), .rd_ones_o(rd_ones),
    .smi_req_o(smi), .trap_sts_o(sts)
  );

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        bm;
    logic        bdev;
    logic [1:0]  en;
    logic        x_fwd;
    logic        x_ones;
    logic        x_smi;
    logic [1:0]  x_sts;
  } vec_t;

  // Selected drive stays 0 throughout the table.
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 16'h01F0, 8'h00, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 2'b01},
    '{1'b0, 1'b1, 16'h01F7, 8'h5A, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 2'b01},
    '{1'b1, 1'b0, 16'h03F6, 8'h00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00},
    '{1'b1, 1'b0, 16'h03F6, 8'h00, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 2'b00},
    '{1'b0, 1'b1, 16'h03F6, 8'h04, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 2'b01},
    '{1'b1, 1'b0, 16'h01EF, 8'h00, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 2'b00},
    '{1'b1, 1'b0, 16'h01F8, 8'h00, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 2'b00},
    '{1'b1, 1'b0, 16'h03F7, 8'h00, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 2'b00},
    '{1'b1, 1'b0, 16'h03F5, 8'h00, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 2'b00},
    '{1'b1, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 2'b10},
    '{1'b0, 1'b1, 16'h0000, 8'h33, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 2'b00},
    '{1'b1, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 1'b1, 2'b01},
    '{1'b1, 1'b0, 16'h01F3, 8'h00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00},
    '{1'b0, 1'b1, 16'h01F6, 8'h00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00}
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic rd, input logic wr, input logic [15:0] a,
                       input logic [7:0] wd, input logic bm, input logic bd,
                       input logic [1:0] en);
    @(negedge clk);
    io_rd = rd; io_wr = wr; io_addr = a; io_wdata = wd;
    bm_hit = bm; bm_dev = bd; trap_en = en;
    #2;
  endtask

  task automatic edge_then_sample();
    @(posedge clk);
    #2;
  endtask

  task automatic go_idle(input logic clr, input logic [1:0] mask);
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0; bm_hit = 1'b0;
    sts_clr = clr; clr_mask = mask;
  endtask

  task automatic clear_all();
    go_idle(1'b1, 2'b11);
    edge_then_sample();
    go_idle(1'b0, 2'b00);
  endtask

  initial begin
    io_rd = 0; io_wr = 0; io_addr = 0; io_wdata = 0; bm_hit = 0;
    bm_dev = 0; trap_en = 0; sts_clr = 0; clr_mask = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset values
    chk("R1", "fwd", 16'(fwd), 16'h0);
    chk("R1", "rd_ones", 16'(rd_ones), 16'h0);
    chk("R1", "smi", 16'(smi), 16'h0);
    chk("R1", "sts", 16'(sts), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: drive 0 selected after reset: arm only drive 1, legacy read forwards
    drive(1, 0, 16'h01F2, 8'h00, 0, 0, 2'b10);
    chk("R1", "fwd with drive 0 selected", 16'(fwd), 16'h1);
    edge_then_sample();
    chk("R1", "no smi", 16'(smi), 16'h0);
    go_idle(0, 0);

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].rd, VEC[i].wr, VEC[i].addr, VEC[i].wdata,
            VEC[i].bm, VEC[i].bdev, VEC[i].en);
      chk("R2/R3/R4/R6", $sformatf("vec%0d fwd", i), 16'(fwd), 16'(VEC[i].x_fwd));
      chk("R5", $sformatf("vec%0d rd_ones", i), 16'(rd_ones), 16'(VEC[i].x_ones));
      edge_then_sample();
      chk("R4/R6", $sformatf("vec%0d smi", i), 16'(smi), 16'(VEC[i].x_smi));
      chk("R7", $sformatf("vec%0d sts", i), 16'(sts), 16'(VEC[i].x_sts));
      go_idle(1'b1, 2'b11);
      edge_then_sample();
      chk("R4", $sformatf("vec%0d smi single cycle", i), 16'(smi), 16'h0);
      chk("R8", $sformatf("vec%0d sts cleared", i), 16'(sts), 16'h0);
      go_idle(0, 0);
    end

    // R9: forwarded select write picks drive 1
    drive(0, 1, 16'h01F6, 8'h10, 0, 0, 2'b00);
    chk("R9", "select write forwarded", 16'(fwd), 16'h1);
    go_idle(0, 0);
    drive(1, 0, 16'h01F0, 8'h00, 0, 0, 2'b10);
    chk("R9", "drive1 armed blocks", 16'(fwd), 16'h0);
    edge_then_sample();
    chk("R9", "status bit of drive 1", 16'(sts), 16'h2);
    clear_all();
    // R9: trapped select write does not move the selection
    drive(0, 1, 16'h01F6, 8'h00, 0, 0, 2'b10);
    chk("R9", "select write trapped", 16'(fwd), 16'h0);
    go_idle(0, 0);
    drive(1, 0, 16'h01F1, 8'h00, 0, 0, 2'b10);
    chk("R9", "still drive 1 after trapped write", 16'(fwd), 16'h0);
    edge_then_sample();
    chk("R9", "still drive 1 status", 16'(sts), 16'h2);
    clear_all();
    drive(0, 1, 16'h01F6, 8'h00, 0, 0, 2'b00);
    go_idle(0, 0);
    drive(1, 0, 16'h01F0, 8'h00, 0, 0, 2'b10);
    chk("R9", "back to drive 0", 16'(fwd), 16'h1);
    go_idle(0, 0);

    // R7: sticky through idle cycles
    drive(1, 0, 16'h01F4, 8'h00, 0, 0, 2'b01);
    go_idle(0, 0);
    repeat (5) edge_then_sample();
    chk("R7", "sticky after idle", 16'(sts), 16'h1);
    // R8: clear of the other bit leaves this one
    go_idle(1, 2'b10);
    edge_then_sample();
    chk("R8", "unmasked bit kept", 16'(sts), 16'h1);
    go_idle(0, 0);
    // R8: set and clear in the same cycle, set wins
    drive(1, 0, 16'h0000, 8'h00, 1, 1, 2'b10);
    sts_clr = 1; clr_mask = 2'b11;
    edge_then_sample();
    chk("R8", "set wins over clear", 16'(sts), 16'h2);
    go_idle(0, 0);
    clear_all();

    // R10: no strobe, nothing happens
    drive(0, 0, 16'h01F0, 8'h00, 1, 0, 2'b11);
    chk("R10", "fwd", 16'(fwd), 16'h0);
    chk("R10", "rd_ones", 16'(rd_ones), 16'h0);
    edge_then_sample();
    chk("R10", "smi", 16'(smi), 16'h0);
    chk("R10", "sts", 16'(sts), 16'h0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule